// File: doc/BRIEF.md
# Serial Interrupt Host Controller

This block is the host end of a single-wire interrupt bus. Every peripheral shares one open-drain line, and all of them run on the same bus clock. The host frames each bus cycle in three parts. It first generates a start frame, or detects one that a peripheral began. It then walks a fixed run of 21 interrupt slots and samples the line in each one. Last, it closes the cycle with a stop frame whose length tells the peripherals whether the next cycle starts again at once (continuous) or waits for a peripheral to request it (quiet).

The sampled slot values are presented as a parallel vector of interrupt levels. Bit i of the vector belongs to slot i in bus order. The vector changes only at the end of a complete cycle, so downstream interrupt logic never sees a half-updated frame. Two inputs configure the block: a mode bit that picks the kind of stop frame, and a two-bit field that picks the width of the start pulse. The pad side is a registered output enable and output value, together with the resolved line level fed back as an input.

Top module: `sirq_host`

## Requirements
- R1: A synchronous active-high reset releases the line (`line_oe` = 0) and clears `irq_levels` to zero.
- R2: Every run of clocks in which the host drives the line low is followed by exactly one clock driven high, and then by a clock in which the line is released.
- R3: A host-initiated start frame drives the line low for 4 clocks when `start_sel` is 00, 6 clocks for 01, 8 clocks for 10 and 4 clocks for 11. The field is sampled on the clock that enters the start frame. One high clock and one released clock follow.
- R4: The first bus cycle after reset always begins with a host-driven start frame, whatever the value of `quiet_mode`.
- R5: After the start frame come 21 slots of three clocks each: sample, recovery and turnaround. The host releases the line in all of them. A low level during the sample clock of slot i marks interrupt i asserted.
- R6: The stop frame drives the line low for 2 clocks when `quiet_mode` was 1, or for 3 clocks when it was 0. The mode is taken on the clock that ends slot 20. One high clock and one released clock follow.
- R7: After a 2-clock stop frame, the host releases the line until it samples `line_in` low. It then drives the line low itself for one clock fewer than the width `start_sel` selects, followed by one high clock and one released clock.
- R8: After a 3-clock stop frame, the next host-driven start frame begins on the clock right after the stop frame's released clock.
- R9: `irq_levels` is loaded on the clock that ends the stop frame's released clock, with the values sampled in that bus cycle. It holds its value at every other clock.
- R10: A peripheral request that arrives in the very first released clock after a quiet stop frame starts a new bus cycle. In that same clock, `irq_levels` takes the finished cycle's values.
- R11: While waiting in quiet mode with no request on the line, the host keeps the line released for any number of clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all activity on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| quiet_mode | input | 1 | 1 requests a quiet stop frame, 0 a continuous one |
| start_sel | input | 2 | Start pulse width select (00=4, 01=6, 10=8, 11=4 clocks) |
| line_in | input | 1 | Resolved level of the shared interrupt line |
| line_oe | output | 1 | Host drives the line when 1, releases it when 0 |
| line_out | output | 1 | Level driven while `line_oe` is 1 |
| irq_levels | output | 21 | Interrupt levels of the last complete cycle, bit i = slot i |

## Verification
Two functions can fall on the same clock. The first is loading the output vector with the finished cycle's slot values. The second is accepting a peripheral's quiet-mode start request. The bench provokes this by pulling the line low in the first released clock after a quiet stop frame. It then judges that the start frame still has the shortened width and that the vector holds exactly the values of the cycle just ended. Sweeps over all four width codes in both modes, with slot patterns computed per frame, check every low, high and released clock against counts derived from the requirements.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

  typedef enum logic [3:0] {
    ST_INIT,
    ST_START,
    ST_START_REC,
    ST_START_TA,
    ST_SLOT_SMP,
    ST_SLOT_REC,
    ST_SLOT_TA,
    ST_STOP,
    ST_STOP_REC,
    ST_STOP_TA,
    ST_QUIET
  } sirq_state_e;

  typedef enum logic [1:0] {
    PAD_RELEASE,
    PAD_LOW,
    PAD_HIGH
  } pad_drive_e;

endpackage

// File: rtl/sirq_width_dec.sv
module sirq_width_dec #(
  parameter int W_SHORT = 4,
  parameter int W_MID   = 6,
  parameter int W_LONG  = 8,
  parameter int CNT_W   = 4
) (
  input  logic [1:0]       sel,
  output logic [CNT_W-1:0] len_cont,
  output logic [CNT_W-1:0] len_quiet
);

  always_comb begin
    unique case (sel)
      2'b01:   len_cont = CNT_W'(W_MID);
      2'b10:   len_cont = CNT_W'(W_LONG);
      default: len_cont = CNT_W'(W_SHORT);
    endcase
  end

  // a peripheral already supplied the first low clock
  assign len_quiet = len_cont - CNT_W'(1);

endmodule

// File: rtl/sirq_sequencer.sv
module sirq_sequencer
  import sirq_pkg::*;
#(
  parameter int NUM_SLOTS  = 21,
  parameter int STOP_QUIET = 2,
  parameter int STOP_CONT  = 3,
  parameter int CNT_W      = 4,
  parameter int SLOT_W     = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_in,
  input  logic              quiet_req,
  input  logic [CNT_W-1:0]  len_cont,
  input  logic [CNT_W-1:0]  len_quiet,
  output pad_drive_e        drive_n,
  output logic              smp_en,
  output logic [SLOT_W-1:0] smp_idx,
  output logic              frame_done,
  output sirq_state_e       state
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

  sirq_state_e       st_q, st_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [SLOT_W-1:0] slot_q, slot_n;
  logic              quiet_q, quiet_n;

  always_comb begin
    st_n       = st_q;
    cnt_n      = cnt_q;
    slot_n     = slot_q;
    quiet_n    = quiet_q;
    smp_en     = 1'b0;
    frame_done = 1'b0;
    unique case (st_q)
      ST_INIT: begin
        st_n    = ST_START;
        cnt_n   = len_cont - CNT_W'(1);
        quiet_n = 1'b0;
      end
      ST_START: begin
        if (cnt_q == '0) st_n = ST_START_REC;
        else             cnt_n = cnt_q - CNT_W'(1);
      end
      ST_START_REC: st_n = ST_START_TA;
      ST_START_TA: begin
        st_n   = ST_SLOT_SMP;
        slot_n = '0;
      end
      ST_SLOT_SMP: begin
        smp_en = 1'b1;
        st_n   = ST_SLOT_REC;
      end
      ST_SLOT_REC: st_n = ST_SLOT_TA;
      ST_SLOT_TA: begin
        if (slot_q == LAST_SLOT) begin
          st_n    = ST_STOP;
          quiet_n = quiet_req;
          cnt_n   = quiet_req ? CNT_W'(STOP_QUIET - 1) : CNT_W'(STOP_CONT - 1);
        end else begin
          slot_n = slot_q + SLOT_W'(1);
          st_n   = ST_SLOT_SMP;
        end
      end
      ST_STOP: begin
        if (cnt_q == '0) st_n = ST_STOP_REC;
        else             cnt_n = cnt_q - CNT_W'(1);
      end
      ST_STOP_REC: st_n = ST_STOP_TA;
      ST_STOP_TA: begin
        frame_done = 1'b1;
        if (quiet_q) begin
          st_n = ST_QUIET;
        end else begin
          st_n  = ST_START;
          cnt_n = len_cont - CNT_W'(1);
        end
      end
      ST_QUIET: begin
        if (!line_in) begin
          st_n  = ST_START;
          cnt_n = len_quiet - CNT_W'(1);
        end
      end
      default: st_n = ST_INIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_INIT;
      cnt_q   <= '0;
      slot_q  <= '0;
      quiet_q <= 1'b0;
    end else begin
      st_q    <= st_n;
      cnt_q   <= cnt_n;
      slot_q  <= slot_n;
      quiet_q <= quiet_n;
    end
  end

  always_comb begin
    unique case (st_n)
      ST_START, ST_STOP:         drive_n = PAD_LOW;
      ST_START_REC, ST_STOP_REC: drive_n = PAD_HIGH;
      default:                   drive_n = PAD_RELEASE;
    endcase
  end

  assign smp_idx = slot_q;
  assign state   = st_q;

endmodule

// File: rtl/sirq_slot_capture.sv
module sirq_slot_capture #(
  parameter int NUM_SLOTS = 21,
  parameter int SLOT_W    = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_en,
  input  logic [SLOT_W-1:0]    smp_idx,
  input  logic                 line_in,
  input  logic                 frame_done,
  output logic [NUM_SLOTS-1:0] levels
);

  logic [NUM_SLOTS-1:0] cap_q;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)                                      cap_q[g] <= 1'b0;
      else if (smp_en && (smp_idx == SLOT_W'(g)))   cap_q[g] <= ~line_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             levels <= '0;
    else if (frame_done) levels <= cap_q;
  end

endmodule

// File: rtl/sirq_pad.sv
module sirq_pad
  import sirq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  pad_drive_e drive_n,
  output logic       line_oe,
  output logic       line_out
);

  always_ff @(posedge clk) begin
    if (rst) begin
      line_oe  <= 1'b0;
      line_out <= 1'b1;
    end else begin
      line_oe  <= (drive_n != PAD_RELEASE);
      line_out <= (drive_n != PAD_LOW);
    end
  end

endmodule

// File: rtl/sirq_host.sv
module sirq_host
  import sirq_pkg::*;
#(
  parameter int NUM_SLOTS   = 21,
  parameter int START_SHORT = 4,
  parameter int START_MID   = 6,
  parameter int START_LONG  = 8,
  parameter int STOP_QUIET  = 2,
  parameter int STOP_CONT   = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 quiet_mode,
  input  logic [1:0]           start_sel,
  input  logic                 line_in,
  output logic                 line_oe,
  output logic                 line_out,
  output logic [NUM_SLOTS-1:0] irq_levels
);

  localparam int MAX_START = (START_LONG > START_MID) ?
                             ((START_LONG > START_SHORT) ? START_LONG : START_SHORT) :
                             ((START_MID > START_SHORT) ? START_MID : START_SHORT);
  localparam int MAX_STOP  = (STOP_CONT > STOP_QUIET) ? STOP_CONT : STOP_QUIET;
  localparam int MAX_LEN   = (MAX_START > MAX_STOP) ? MAX_START : MAX_STOP;
  localparam int CNT_W     = $clog2(MAX_LEN + 1);
  localparam int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  logic [CNT_W-1:0]  len_cont;
  logic [CNT_W-1:0]  len_quiet;
  pad_drive_e        drive_n;
  logic              smp_en;
  logic [SLOT_W-1:0] smp_idx;
  logic              frame_done;
  sirq_state_e       seq_state;

  sirq_width_dec #(
    .W_SHORT (START_SHORT),
    .W_MID   (START_MID),
    .W_LONG  (START_LONG),
    .CNT_W   (CNT_W)
  ) u_width (
    .sel       (start_sel),
    .len_cont  (len_cont),
    .len_quiet (len_quiet)
  );

  sirq_sequencer #(
    .NUM_SLOTS  (NUM_SLOTS),
    .STOP_QUIET (STOP_QUIET),
    .STOP_CONT  (STOP_CONT),
    .CNT_W      (CNT_W),
    .SLOT_W     (SLOT_W)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .line_in    (line_in),
    .quiet_req  (quiet_mode),
    .len_cont   (len_cont),
    .len_quiet  (len_quiet),
    .drive_n    (drive_n),
    .smp_en     (smp_en),
    .smp_idx    (smp_idx),
    .frame_done (frame_done),
    .state      (seq_state)
  );

  sirq_slot_capture #(
    .NUM_SLOTS (NUM_SLOTS),
    .SLOT_W    (SLOT_W)
  ) u_cap (
    .clk        (clk),
    .rst        (rst),
    .smp_en     (smp_en),
    .smp_idx    (smp_idx),
    .line_in    (line_in),
    .frame_done (frame_done),
    .levels     (irq_levels)
  );

  sirq_pad u_pad (
    .clk      (clk),
    .rst      (rst),
    .drive_n  (drive_n),
    .line_oe  (line_oe),
    .line_out (line_out)
  );

endmodule

// File: rtl/sirq_host_chk.sv
module sirq_host_chk
  import sirq_pkg::*;
#(
  parameter int NUM_SLOTS = 21
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 line_in,
  input logic                 line_oe,
  input logic                 line_out,
  input logic [NUM_SLOTS-1:0] irq_levels,
  input sirq_state_e          seq_state
);

  logic drv_low, drv_high;
  assign drv_low  = line_oe && !line_out;
  assign drv_high = line_oe && line_out;

  // R2: the end of a low run is always a single high clock
  assert_low_then_high_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(drv_low) && !drv_low) |-> drv_high);

  // R2: a high clock is always followed by release
  assert_high_then_release_R2: assert property (@(posedge clk) disable iff (rst)
    drv_high |=> !line_oe);

  // R4: leaving reset starts a host-driven start frame
  assert_first_start_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !rst) |=> drv_low);

  // R5: host never drives during slot phases
  assert_slot_released_R5: assert property (@(posedge clk) disable iff (rst)
    (seq_state inside {ST_SLOT_SMP, ST_SLOT_REC, ST_SLOT_TA}) |-> !line_oe);

  // R7: a sampled low in quiet idle is taken over on the next clock
  assert_quiet_takeover_R7: assert property (@(posedge clk) disable iff (rst)
    (seq_state == ST_QUIET && !line_in) |=> drv_low);

  // R9: levels change only after the stop frame's release clock
  assert_levels_update_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(irq_levels) |-> ($past(seq_state) == ST_STOP_TA));

  // R11: quiet idle keeps the line released
  assert_quiet_released_R11: assert property (@(posedge clk) disable iff (rst)
    (seq_state == ST_QUIET) |-> !line_oe);

endmodule

bind sirq_host sirq_host_chk #(.NUM_SLOTS(NUM_SLOTS)) u_sirq_host_chk (
  .clk        (clk),
  .rst        (rst),
  .line_in    (line_in),
  .line_oe    (line_oe),
  .line_out   (line_out),
  .irq_levels (irq_levels),
  .seq_state  (seq_state)
);

// File: tb/sirq_host_bench.sv
`timescale 1ns/1ps
module sirq_host_bench;

  localparam int NS = 21;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          quiet_mode = 1'b0;
  logic [1:0]    start_sel = 2'b00;
  logic          periph_low = 1'b0;
  logic          line_in;
  logic          line_oe, line_out;
  logic [NS-1:0] irq_levels;
  logic [NS-1:0] prev;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  // resolved open-drain line with pull-up
  assign line_in = line_oe ? line_out : ~periph_low;

  sirq_host u_sirq_host (
    .clk        (clk),
    .rst        (rst),
    .quiet_mode (quiet_mode),
    .start_sel  (start_sel),
    .line_in    (line_in),
    .line_oe    (line_oe),
    .line_out   (line_out),
    .irq_levels (irq_levels)
  );

  task automatic step();
    @(negedge clk);
  endtask

  // line code: 0 released, 1 driven low, 2 driven high
  task automatic check_line(input string req, input int exp);
    int act;
    act = !line_oe ? 0 : (line_out ? 2 : 1);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s line code: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_vec(input string req, input logic [NS-1:0] exp);
    checks++;
    if (irq_levels !== exp) begin
      fails++;
      $display("FAIL %s irq_levels: actual=%h expected=%h", req, irq_levels, exp);
    end
  endtask

  function automatic int width_of(input logic [1:0] sel);
    case (sel)
      2'b01:   return 6;
      2'b10:   return 8;
      default: return 4;
    endcase
  endfunction

  function automatic logic [NS-1:0] pat_of(input int k);
    logic [31:0] t;
    if (k == 0) return '1;
    if (k == 1) return '0;
    t = (32'(k) * 32'h9E37_79B1) ^ (32'h1 << (k % NS));
    return t[NS+4:5];
  endfunction

  // entered with outputs showing the first host-low start clock
  task automatic run_frame(input int nlow, input logic [NS-1:0] pat,
                           input logic qnext, input logic [1:0] nsel);
    int stop_len;
    quiet_mode = qnext;
    for (int i = 0; i < nlow; i++) begin
      check_line("R3", 1);
      check_vec("R9", prev);
      step();
    end
    check_line("R2", 2); step();
    check_line("R2", 0); step();
    start_sel = nsel;
    for (int s = 0; s < NS; s++) begin
      periph_low = pat[s];
      check_line("R5", 0);
      check_vec("R9", prev);
      step();
      periph_low = 1'b0;
      check_line("R5", 0); step();
      check_line("R5", 0); step();
    end
    stop_len = qnext ? 2 : 3;
    for (int i = 0; i < stop_len; i++) begin
      check_line("R6", 1); step();
    end
    check_line("R6", 2); step();
    check_line("R6", 0);
    check_vec("R9", prev);
    step();
    check_vec("R5", pat);
    prev = pat;
  endtask

  // entered at the first released clock after a quiet stop frame
  task automatic quiet_start(input int idle, input logic [1:0] sel);
    start_sel = sel;
    for (int i = 0; i < idle; i++) begin
      check_line("R11", 0);
      check_vec("R9", prev);
      step();
    end
    periph_low = 1'b1;
    check_line("R7", 0);
    step();
    periph_low = 1'b0;
  endtask

  initial begin
    prev = '0;
    quiet_mode = 1'b1;
    start_sel  = 2'b10;
    repeat (3) @(posedge clk);
    step();
    check_line("R1", 0);
    check_vec("R1", '0);
    rst = 1'b0;
    step();
    check_line("R4", 1);
    run_frame(width_of(2'b10), pat_of(0), 1'b0, 2'b00);

    for (int k = 0; k < 4; k++) begin
      check_line("R8", 1);
      run_frame(width_of(2'(k)), pat_of(k + 1), (k == 3), 2'(k + 1));
    end

    for (int k = 0; k < 4; k++) begin
      // k==3 requests in the first idle clock: R10
      quiet_start((k == 3) ? 0 : 6 * (k + 1), 2'(k));
      if (k == 3) check_vec("R10", prev);
      run_frame(width_of(2'(k)) - 1, pat_of(5 + k), (k != 3), 2'b01);
    end

    check_line("R8", 1);
    run_frame(width_of(2'b01), pat_of(9), 1'b1, 2'b00);
    quiet_start(30, 2'b11);
    run_frame(width_of(2'b11) - 1, pat_of(10), 1'b1, 2'b00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule